// File: doc/BRIEF.md
# Vertical Laplacian Sharpening Stage

This block sharpens an 8-bit pixel stream along the vertical axis only. It holds two full lines in two cascaded line stores. For each arriving pixel it has three samples from the same column: the arriving pixel is the line below (B), the first store supplies the current line (N), and the second store supplies the line above (A). It outputs N' = N + K·(2N − (A + B)), rounded to an integer and clamped to 0..255. K is an unsigned coefficient with two fractional bits, given with each pixel.

The input carries a valid strobe and a line-start marker. The marker is set on the first pixel of each line, and line length is simply the spacing between markers. The output is the filtered current-line pixel, with a valid strobe and a line-start flag. Both arrive a fixed two cycles after the input pixel that produced them. The line-store depth is the parameter `MAX_LEN` and may be set as high as 5120.

Top module: `vsharpen_lap`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `out_valid`, `out_sol` and `out_pix` are all 0.
- R2: `out_valid` is high in cycle t+2 exactly when `in_valid` was high in cycle t. `out_sol` is high in cycle t+2 exactly when `in_valid` and `in_sol` were both high in cycle t.
- R3: A pixel with `in_sol` high is column 0. Each further valid pixel takes the next column, and cycles with `in_valid` low do not advance the column. N and A are the values last stored at that same column one and two lines earlier. The stores are never cleared, so a column not written in a line keeps its older value.
- R4: From the third line after reset onward, `out_pix` = clamp(N + round(K·(2N − A − B)/4)). Here K is the 4-bit `k_coef` value read as an unsigned number with 2 fractional bits.
- R5: When the scaled term lies exactly halfway between two integers, it rounds toward +infinity. So a product of +2/4 rounds to +1 and a product of −2/4 rounds to 0.
- R6: A result below 0 is output as 0, and a result above 255 is output as 255.
- R7: While the first line after reset is arriving, `out_pix` is 0. While the second line arrives, `out_pix` is the first line's pixel at the same column, unfiltered. Valid pixels that arrive before any line-start marker belong to the first line.
- R8: With `k_coef` = 0, `out_pix` equals N.
- R9: `k_coef` is sampled together with each valid pixel and may differ from pixel to pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_sol | input | 1 | Marks the first pixel of a line |
| in_pix | input | 8 | Incoming pixel (line below) |
| k_coef | input | 4 | Laplacian gain, unsigned, 2 fractional bits |
| out_valid | output | 1 | Output pixel strobe |
| out_sol | output | 1 | Line-start flag aligned with the output |
| out_pix | output | 8 | Sharpened current-line pixel |

## Verification
Every output is due two clock cycles after the input cycle that produced it: the valid strobe, the line-start flag and the pixel value all follow that rule. The bench drives inputs on the falling edge and records the expected triple for each driven cycle in a small ring. On the falling edge two steps later it compares the outputs against that entry. Expected pixels come from a bench model of the two line stores and the formula, which tracks the column and line index from the markers alone.

// File: rtl/vsharpen_lap.sv
`timescale 1ns/1ps
module vsharpen_lap #(
  parameter int PW      = 8,
  parameter int KW      = 4,
  parameter int KFRAC   = 2,
  parameter int MAX_LEN = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic [PW-1:0] in_pix,
  input  logic [KW-1:0] k_coef,
  output logic          out_valid,
  output logic          out_sol,
  output logic [PW-1:0] out_pix
);
  localparam int CW  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int SW  = PW + 4;
  localparam int PRW = SW + KW + 1;
  localparam logic [CW-1:0] LAST_COL = CW'(MAX_LEN - 1);
  localparam logic signed [PRW-1:0] HALF = PRW'(1 << (KFRAC - 1));
  localparam logic signed [PRW-1:0] TOP  = PRW'((1 << PW) - 1);

  logic [PW-1:0] mem_cur [MAX_LEN];
  logic [PW-1:0] mem_up  [MAX_LEN];

  logic [CW-1:0] col_q, col;
  logic          seen_q;
  logic [1:0]    idx_q, idx;

  assign col = in_sol ? '0 : col_q;
  assign idx = (in_sol && seen_q && idx_q != 2'd2) ? idx_q + 2'd1 : idx_q;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      mem_cur[col] <= in_pix;
      mem_up[col]  <= mem_cur[col];
    end
  end

  logic          s1_valid, s1_sol, s1_filt;
  logic [PW-1:0] s1_a, s1_n, s1_b;
  logic [KW-1:0] s1_k;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q    <= '0;
      seen_q   <= 1'b0;
      idx_q    <= '0;
      s1_valid <= 1'b0;
      s1_sol   <= 1'b0;
      s1_filt  <= 1'b0;
      s1_a     <= '0;
      s1_n     <= '0;
      s1_b     <= '0;
      s1_k     <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_sol   <= in_valid & in_sol;
      if (in_valid) begin
        col_q   <= (col == LAST_COL) ? col : col + CW'(1);
        seen_q  <= seen_q | in_sol;
        idx_q   <= idx;
        s1_b    <= in_pix;
        s1_n    <= (idx == 2'd0) ? '0 : mem_cur[col];
        s1_a    <= mem_up[col];
        s1_k    <= k_coef;
        s1_filt <= (idx == 2'd2);
      end
    end
  end

  logic signed [SW-1:0]  diff;
  logic signed [PRW-1:0] prod, rnd, sum;
  logic [PW-1:0]         clamped, result;

  assign diff = $signed({{(SW-PW-1){1'b0}}, s1_n, 1'b0})
              - $signed({{(SW-PW){1'b0}}, s1_a})
              - $signed({{(SW-PW){1'b0}}, s1_b});
  assign prod = PRW'(diff) * $signed(PRW'({1'b0, s1_k}));
  assign rnd  = (prod + HALF) >>> KFRAC;
  assign sum  = rnd + $signed(PRW'({1'b0, s1_n}));

  always_comb begin
    if (sum < 0)        clamped = '0;
    else if (sum > TOP) clamped = '1;
    else                clamped = sum[PW-1:0];
  end

  assign result = s1_filt ? clamped : s1_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_sol   <= s1_sol;
      if (s1_valid) out_pix <= result;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  assert_sol_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sol) |-> ##2 out_sol);
  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_filt) |=> out_pix == $past(s1_n));
  assert_kzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_k == '0) |=> out_pix == $past(s1_n));
endmodule

// File: tb/tb_vsharpen_lap.sv
`timescale 1ns/1ps
module tb_vsharpen_lap;
  localparam int MAXL = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sol = 1'b0;
  logic [7:0] in_pix = '0;
  logic [3:0] k_coef = '0;
  logic       out_valid, out_sol;
  logic [7:0] out_pix;

  vsharpen_lap dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_pix(in_pix), .k_coef(k_coef),
    .out_valid(out_valid), .out_sol(out_sol), .out_pix(out_pix)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit       rv [4];
  bit       rs [4];
  int       rp [4];
  string    rt [4];

  int  m_cur [2048];
  int  m_up  [2048];
  int  m_col = 0, m_idx = 0;
  bit  m_seen = 1'b0;

  function automatic int model_pix(int a, int n, int b, int k, int idx, output string tag);
    int d, p, r, s;
    if (idx < 2) begin tag = "R7"; return n; end
    d = 2*n - a - b;
    p = d * k;
    r = (p + 2) >>> 2;
    s = n + r;
    if (k == 0) tag = "R8";
    else if (s < 0 || s > 255) tag = "R6";
    else if ((p & 3) == 2) tag = "R5";
    else tag = "R4 R3 R9";
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(bit v, bit s, int p, int k);
    int slot, col, idx, n, a;
    string tag;
    @(negedge clk);
    slot = (cyc + 2) & 3;
    check("R2 valid", int'(out_valid), int'(rv[slot]));
    if (rv[slot]) begin
      check("R2 sol", int'(out_sol), int'(rs[slot]));
      check(rt[slot], int'(out_pix), rp[slot]);
    end
    in_valid = v; in_sol = s; in_pix = p[7:0]; k_coef = k[3:0];
    slot = cyc & 3;
    rv[slot] = v; rs[slot] = v & s;
    if (v) begin
      col = s ? 0 : m_col;
      idx = (s && m_seen && m_idx != 2) ? m_idx + 1 : m_idx;
      n = (idx == 0) ? 0 : m_cur[col];
      a = m_up[col];
      rp[slot] = model_pix(a, n, p, k, idx, tag);
      rt[slot] = tag;
      m_up[col] = m_cur[col];
      m_cur[col] = p;
      m_col = (col == 2047) ? col : col + 1;
      m_seen = m_seen | s;
      m_idx = idx;
    end
    cyc++;
  endtask

  task automatic send_line(int len, int mode, int base, int k, int gaps);
    for (int c = 0; c < len; c++) begin
      int p;
      while (gaps != 0 && ($urandom % 4) == 0) step(1'b0, 1'b0, $urandom % 256, $urandom % 16);
      case (mode)
        0: p = base;
        1: p = c;
        default: begin
          p = $urandom % 256;
          if (($urandom % 8) == 0) p = (($urandom % 2) != 0) ? 255 : 0;
        end
      endcase
      step(1'b1, c == 0, p, (k < 0) ? int'($urandom % 16) : k);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check("R1 valid", int'(out_valid), 0);
    check("R1 sol", int'(out_sol), 0);
    check("R1 pix", int'(out_pix), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", int'(out_valid), 0);
    check("R1 pix after release", int'(out_pix), 0);
    // R7: first two lines pass through; full-width so every column is stored
    send_line(MAXL, 1, 0, 15, 0);
    send_line(MAXL, 0, 255, 15, 1);
    // R6: saturation high then low
    send_line(MAXL, 0, 0, 15, 0);
    send_line(MAXL, 0, 255, 15, 0);
    // R5: rounding ties in both directions
    send_line(MAXL, 0, 100, 2, 0);
    send_line(MAXL, 0, 100, 2, 0);
    send_line(MAXL, 0, 101, 2, 0);
    send_line(MAXL, 0, 101, 2, 0);
    // R8: zero gain
    send_line(MAXL / 2, 2, 0, 0, 1);
    // R3, R4, R9: random lengths, gaps, per-pixel gain
    for (int l = 0; l < 60; l++)
      send_line(4 + int'($urandom % (MAXL - 3)), 2, 0, -1, 1);
    repeat (4) step(1'b0, 1'b0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule